// File: doc/BRIEF.md
# Hierarchical Carry-Lookahead Adder

This block adds two WIDTH-bit unsigned operands and a carry input, producing a WIDTH-bit sum and a carry output in a single combinational pass. It has no clock and no state. The carries do not ripple from bit to bit. Instead they come from a tree of identical four-input lookahead units.

Each leaf cell forms a propagate term (a XOR b), a generate term (a AND b) and its sum bit. Every lookahead unit has two jobs. It folds four child (propagate, generate) pairs into one pair for its parent, and it hands a carry back down to each of its four children. The same unit serves both as a 4-bit group and as a super-group at every higher level. This gives a tree depth of ceil(log4(WIDTH)).

When WIDTH is not a power of four, the leaf row is filled out with padding positions that propagate and never generate. Their sum bits are dropped. The carry output is taken from the root pair as G* OR (P* AND carry-in).

Top module: `cla_adder`

## Requirements
- R1: For every operand pair and carry-in, {carryOut, sumOut} equals opA + opB + carryIn taken as a WIDTH+1-bit unsigned sum, settled in the same cycle the inputs change.
- R2: Each bit i behaves as a full adder: its propagate is opA[i] XOR opB[i], its generate is opA[i] AND opB[i], its sum is propagate XOR the carry into bit i, and the carry into bit i+1 is the carry into bit i when propagate is 1 and the generate term otherwise.
- R3: When both operands are all ones, every bit generates, so carryOut is 1 whatever carryIn is, and sumOut is all ones except that bit 0 equals carryIn.
- R4: With both operands zero, sumOut equals carryIn in bit 0 with all other bits 0, and carryOut is 0.
- R5: A carry generated inside the lowest 4-bit group reaches the next group: 0xF + 0x1 gives 0x10 with carryOut 0 for every width above 4.
- R6: A carry crosses a whole super-group of 16 bits: 0xFFFF + 0x1 gives 0x10000 for widths above 16, and gives sum 0 with carryOut 1 at width 16.
- R7: When every bit propagates (opB is the bitwise inverse of opA), carryOut equals carryIn and sumOut is all ones for carry-in 0 and all zeros for carry-in 1.
- R8: A width that is not a power of four (24) gives exact results. The carry out of bit WIDTH-1 appears on carryOut, and the padded positions never change the result.
- R9: The 64-bit configuration, which has three lookahead levels, gives exact results for random and corner operands.
- R10: Alternating bit patterns (0xAA..A and 0x55..5, each added to itself and to the other) give exact sums and carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First addend |
| opB | input | WIDTH | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | WIDTH | Low WIDTH bits of the sum |
| carryOut | output | 1 | Carry out of bit WIDTH-1 |

## Verification
The hardest case to reach from the ports is a carry that has to cross the full width through the top of the tree. Random operands almost never make every bit propagate at once, or make a carry travel through a whole padded super-group. The stimulus therefore forces these cases directly. It uses inverse operand pairs with both carry-in values, all-ones pairs, and carries launched at the 4-bit and 16-bit boundaries. It also walks a single generating bit across all 64 positions. The same operand stream drives a 16-bit, a 24-bit (padded) and a 64-bit instance, so every case is seen at two, three and three tree levels.

// File: rtl/cla_pkg.sv
`timescale 1ns/1ps
package cla_pkg;

  // Fan-in of every lookahead unit, at every level of the tree.
  localparam int GROUP = 4;

  typedef struct packed {
    logic prop;
    logic gen;
  } pgPair_t;

  // Number of lookahead levels needed so that GROUP**levels covers width.
  function automatic int treeLevels(input int width);
    int lv;
    int span;
    lv   = 1;
    span = GROUP;
    while (span < width) begin
      lv++;
      span = span * GROUP;
    end
    return lv;
  endfunction

  // Index of the first node of a level in the flattened node vectors.
  function automatic int levelBase(input int level, input int padWidth);
    int base;
    base = 0;
    for (int j = 0; j < level; j++) base += padWidth >> (2 * j);
    return base;
  endfunction

endpackage

// File: rtl/cla_bit_cell.sv
`timescale 1ns/1ps
module cla_bit_cell (
  input  logic a,
  input  logic b,
  input  logic carryIn,
  output logic prop,
  output logic gen,
  output logic sum
);
  always_comb begin
    prop = a ^ b;
    gen  = a & b;
    sum  = prop ^ carryIn;
  end
endmodule

// File: rtl/cla_lookahead4.sv
`timescale 1ns/1ps
module cla_lookahead4
  import cla_pkg::*;
(
  input  logic [3:0] kidP,
  input  logic [3:0] kidG,
  input  logic       carryIn,
  output logic [3:1] kidCarry,
  output pgPair_t    grp
);
  always_comb begin
    kidCarry[1] = kidG[0] | (kidP[0] & carryIn);
    kidCarry[2] = kidG[1] | (kidP[1] & kidG[0]) | (kidP[1] & kidP[0] & carryIn);
    kidCarry[3] = kidG[2] | (kidP[2] & kidG[1]) | (kidP[2] & kidP[1] & kidG[0])
                | (kidP[2] & kidP[1] & kidP[0] & carryIn);
    grp.prop    = &kidP;
    grp.gen     = kidG[3] | (kidP[3] & kidG[2]) | (kidP[3] & kidP[2] & kidG[1])
                | (kidP[3] & kidP[2] & kidP[1] & kidG[0]);
  end
endmodule

// File: rtl/cla_tree.sv
`timescale 1ns/1ps
module cla_tree
  import cla_pkg::*;
#(
  parameter  int LEVELS = 2,
  localparam int PAD_W  = 1 << (2 * LEVELS),
  localparam int TOTAL  = levelBase(LEVELS + 1, PAD_W)
) (
  input  logic [PAD_W-1:0] leafP,
  input  logic [PAD_W-1:0] leafG,
  input  logic             carryIn,
  output logic [PAD_W-1:0] leafCarry,
  output logic             rootP,
  output logic             rootG
);
  // Flattened node storage: level 0 (leaves) first, the root last.
  logic [TOTAL-1:0] nodeP;
  logic [TOTAL-1:0] nodeG;
  logic [TOTAL-1:0] nodeC;

  assign nodeP[PAD_W-1:0] = leafP;
  assign nodeG[PAD_W-1:0] = leafG;
  assign leafCarry        = nodeC[PAD_W-1:0];
  assign nodeC[TOTAL-1]   = carryIn;
  assign rootP            = nodeP[TOTAL-1];
  assign rootG            = nodeG[TOTAL-1];

  for (genvar k = 1; k <= LEVELS; k++) begin : g_level
    localparam int COUNT    = PAD_W >> (2 * k);
    localparam int BASE     = levelBase(k, PAD_W);
    localparam int KID_BASE = levelBase(k - 1, PAD_W);
    for (genvar j = 0; j < COUNT; j++) begin : g_node
      pgPair_t grp;
      cla_lookahead4 u_la (
        .kidP    (nodeP[KID_BASE + GROUP*j +: GROUP]),
        .kidG    (nodeG[KID_BASE + GROUP*j +: GROUP]),
        .carryIn (nodeC[BASE + j]),
        .kidCarry(nodeC[KID_BASE + GROUP*j + 1 +: GROUP-1]),
        .grp     (grp)
      );
      assign nodeC[KID_BASE + GROUP*j] = nodeC[BASE + j];
      assign nodeP[BASE + j]           = grp.prop;
      assign nodeG[BASE + j]           = grp.gen;
    end
  end
endmodule

// File: rtl/cla_adder.sv
`timescale 1ns/1ps
module cla_adder
  import cla_pkg::*;
#(
  parameter  int WIDTH  = 16,
  localparam int LEVELS = treeLevels(WIDTH),
  localparam int PAD_W  = 1 << (2 * LEVELS)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  logic [PAD_W-1:0] leafP;
  logic [PAD_W-1:0] leafG;
  logic [PAD_W-1:0] leafCarry;
  logic [WIDTH-1:0] bitP;
  logic [WIDTH-1:0] bitG;
  logic [WIDTH-1:0] bitC;
  logic             rootP;
  logic             rootG;

  for (genvar i = 0; i < PAD_W; i++) begin : g_leaf
    if (i < WIDTH) begin : g_real
      cla_bit_cell u_cell (
        .a      (opA[i]),
        .b      (opB[i]),
        .carryIn(leafCarry[i]),
        .prop   (bitP[i]),
        .gen    (bitG[i]),
        .sum    (sumOut[i])
      );
      assign leafP[i] = bitP[i];
      assign leafG[i] = bitG[i];
    end else begin : g_pad
      // Padding passes any carry straight through and never creates one.
      assign leafP[i] = 1'b1;
      assign leafG[i] = 1'b0;
    end
  end

  if (PAD_W > WIDTH) begin : g_padSink
    logic unusedPadCarry;
    assign unusedPadCarry = ^leafCarry[PAD_W-1:WIDTH];
  end

  assign bitC = leafCarry[WIDTH-1:0];

  cla_tree #(.LEVELS(LEVELS)) u_tree (
    .leafP    (leafP),
    .leafG    (leafG),
    .carryIn  (carryIn),
    .leafCarry(leafCarry),
    .rootP    (rootP),
    .rootG    (rootG)
  );

  assign carryOut = rootG | (rootP & carryIn);
endmodule

// File: rtl/cla_adder_chk.sv
`timescale 1ns/1ps
module cla_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic [WIDTH-1:0] sumOut,
  input logic             carryOut,
  input logic [WIDTH-1:0] bitP,
  input logic [WIDTH-1:0] bitG,
  input logic [WIDTH-1:0] bitC,
  input logic             rootP,
  input logic             rootG
);
  always_comb begin
    if (!$isunknown({opA, opB, carryIn})) begin
      AST_SUM_EXACT: assert ({carryOut, sumOut} == ({1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn}))
        else $error("sum mismatch");                                          // R1
      AST_FIRST_CARRY: assert (bitC[0] == carryIn)
        else $error("carry into bit 0 differs from carry-in");                // R2
      for (int i = 1; i < WIDTH; i++) begin
        AST_BIT_MUX: assert (bitC[i] == (bitP[i-1] ? bitC[i-1] : bitG[i-1]))
          else $error("tree carry %0d breaks the bit recurrence", i);         // R2
      end
      AST_LAST_CARRY: assert (carryOut == (bitP[WIDTH-1] ? bitC[WIDTH-1] : bitG[WIDTH-1]))
        else $error("carry-out differs from carry out of top bit");           // R8
      AST_ROOT_GEN: assert (!rootG || carryOut)
        else $error("root generate without carry-out");                       // R3
      AST_ROOT_PROP: assert (!rootP || (carryOut == carryIn))
        else $error("full propagate did not pass carry-in");                  // R7
      AST_ROOT_P_ALL: assert (rootP == (&(opA ^ opB)))
        else $error("root propagate disagrees with the operand bits");        // R8
    end
  end
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .opA     (opA),
  .opB     (opB),
  .carryIn (carryIn),
  .sumOut  (sumOut),
  .carryOut(carryOut),
  .bitP    (bitP),
  .bitG    (bitG),
  .bitC    (bitC),
  .rootP   (rootP),
  .rootG   (rootG)
);

// File: tb/sim_cla_adder.sv
`timescale 1ns/1ps
module sim_cla_adder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  logic [63:0] stimA = '0;
  logic [63:0] stimB = '0;
  logic        stimC = 1'b0;

  logic [15:0] sum0;
  logic        co0;
  logic [23:0] sum1;
  logic        co1;
  logic [63:0] sum2;
  logic        co2;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  cla_adder #(.WIDTH(16)) u0 (.opA(stimA[15:0]), .opB(stimB[15:0]), .carryIn(stimC), .sumOut(sum0), .carryOut(co0));
  cla_adder #(.WIDTH(24)) u1 (.opA(stimA[23:0]), .opB(stimB[23:0]), .carryIn(stimC), .sumOut(sum1), .carryOut(co1));
  cla_adder #(.WIDTH(64)) u2 (.opA(stimA),       .opB(stimB),       .carryIn(stimC), .sumOut(sum2), .carryOut(co2));

  // Behavioural reference: plain integer addition on the low w bits.
  function automatic logic [64:0] refAdd(input int w, input logic [63:0] a, input logic [63:0] b, input logic c);
    logic [64:0] m;
    m = (w >= 64) ? {1'b0, {64{1'b1}}} : ((65'd1 << w) - 65'd1);
    return (({1'b0, a}) & m) + (({1'b0, b}) & m) + {64'd0, c};
  endfunction

  task automatic compareOne(input string tag, input int w, input logic [63:0] gotSum, input logic gotCout);
    logic [64:0] e;
    logic [63:0] expSum;
    e      = refAdd(w, stimA, stimB, stimC);
    expSum = e[63:0];
    if (w < 64) expSum = expSum & ((64'd1 << w) - 64'd1);
    checks++;
    if (gotSum !== expSum || gotCout !== e[w]) begin
      fails++;
      $display("FAIL %s w=%0d a=%h b=%h c=%0d: sum=%h cout=%0d expected sum=%h cout=%0d",
               tag, w, stimA, stimB, stimC, gotSum, gotCout, expSum, e[w]);
    end
  endtask

  task automatic applyVec(input logic [63:0] a, input logic [63:0] b, input logic c, input string tag);
    @(posedge clk);
    #1;
    stimA = a;
    stimB = b;
    stimC = c;
    @(negedge clk);
    compareOne(tag, 16, {48'd0, sum0}, co0);
    compareOne({tag, " R8"}, 24, {40'd0, sum1}, co1);
    compareOne({tag, " R9"}, 64, sum2, co2);
  endtask

  localparam logic [63:0] ONES = {64{1'b1}};
  localparam logic [63:0] ALT_A = {16{4'hA}};
  localparam logic [63:0] ALT_5 = {16{4'h5}};

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R4: quiet state after start-up, zero operands with both carry-ins
    applyVec('0, '0, 1'b0, "R4 zero");
    applyVec('0, '0, 1'b1, "R4 zero+cin");

    // R3: every bit generates, carry-out set for both carry-ins
    applyVec(ONES, ONES, 1'b0, "R3 gen cin0");
    applyVec(ONES, ONES, 1'b1, "R3 gen cin1");

    // R7: every bit propagates, carry-out follows carry-in
    applyVec(ALT_A, ALT_5, 1'b0, "R7 prop cin0");
    applyVec(ALT_A, ALT_5, 1'b1, "R7 prop cin1");
    applyVec(ONES, '0, 1'b1, "R7 ones+cin");
    applyVec(64'h0123_4567_89AB_CDEF, ~64'h0123_4567_89AB_CDEF, 1'b1, "R7 inverse pair");

    // R5: carry leaves the lowest 4-bit group
    applyVec(64'hF, 64'h1, 1'b0, "R5 group edge");
    applyVec(64'hE, 64'h1, 1'b1, "R5 group edge via cin");

    // R6: carry crosses a 16-bit super-group
    applyVec(64'hFFFF, 64'h1, 1'b0, "R6 super edge");
    applyVec(64'hFFFF_FFFF, 64'h0, 1'b1, "R6 deep run");

    // R10: alternating patterns
    applyVec(ALT_A, ALT_A, 1'b0, "R10 aa+aa");
    applyVec(ALT_5, ALT_5, 1'b1, "R10 55+55");
    applyVec(ALT_5, ALT_A, 1'b1, "R10 55+aa");

    // R2: single generating bit walked across every position
    for (int k = 0; k < 64; k++) begin
      applyVec(64'd1 << k, 64'd1 << k, 1'b0, "R2 walk gen");
      applyVec(64'd1 << k, 64'd0, 1'b1, "R2 walk sum");
    end

    // R1: random operands and carry-ins
    for (int n = 0; n < 400; n++) begin
      applyVec({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule